// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through a set of one-bit channel flags, with no payload storage. Each processor owns one flag per channel that says "my outgoing channel n is occupied". The sender sets its own flag for a channel. The receiver sees the peer's flag and acknowledges it, which clears it. When the flag clears, the sender learns that the channel is free again.

Each processor has a bank of four registers: control, mask, set/clear command and own-flag status. Bank k starts at byte address k*0x10. Each processor also gets two level-sensitive, registered interrupt lines:
- The receive line fires on unmasked peer flags that are occupied.
- The transmit line fires on unmasked own flags that are free.

A read-only channel-count register and a version register sit near the top of the map. Each processor has its own simple register port. A write or a read is presented for one cycle, and read data comes back on the following cycle.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: Reset state:
  - All flags are clear (free).
  - Every valid mask bit reads as 1.
  - Both interrupt enables in each bank read as 0.
  - All four interrupt outputs are low.
- R2: Register layout and access rules:
  - Bank k (k = 0 or 1) holds control at k*0x10+0x0, mask at +0x4, command at +0x8 and status at +0xC.
  - Control bit 0 enables the receive interrupt and bit 16 enables the transmit interrupt.
  - Either port may read either bank.
  - A write from port p lands only in bank p. A write to the other bank is ignored.
- R3: Mask bits 15:0 mask receive events per channel, and bits 31:16 mask transmit events per channel. A 1 means masked. The mask reads back as written.
- R4: Writing 1 to command bit 16+n from port p sets p's flag for channel n. The status register of bank p shows its own flags in bits n.
- R5: Writing 1 to command bit n from port p clears the peer's flag for channel n. If the same flag is set by its owner and cleared by the peer in the same cycle, it ends up set.
- R6: Command bits written as 0 change nothing. The command register always reads as zero.
- R7: The receive interrupt of processor p rises one cycle after all of the following hold:
  - its receive enable is 1;
  - some peer flag is set;
  - that channel's receive mask bit is 0.
  It falls one cycle after any of these stops holding.
- R8: The transmit interrupt of processor p is high one cycle after all of the following hold:
  - its transmit enable is 1;
  - some own flag is clear;
  - that channel's transmit mask bit is 0.
  It is low otherwise.
- R9: Reads of the two fixed registers:
  - Address 0x3F0 reads the channel count in bits 7:0.
  - Address 0x3F4 reads the minor revision in bits 3:0 and the major revision in bits 7:4.
- R10: Flag, mask and command bits for channels at or above the channel count are ignored and read as zero.
- R11: Read data is registered. It is valid the cycle after a read request and is zero in any cycle that follows no read. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_sel | input | 1 | Processor 0 access request |
| p0_we | input | 1 | Processor 0 write (1) or read (0) |
| p0_addr | input | 10 | Processor 0 byte address |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data, one cycle after request |
| p1_sel | input | 1 | Processor 1 access request |
| p1_we | input | 1 | Processor 1 write (1) or read (0) |
| p1_addr | input | 10 | Processor 1 byte address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data, one cycle after request |
| p0_rx_irq | output | 1 | Processor 0 receive interrupt |
| p0_tx_irq | output | 1 | Processor 0 transmit interrupt |
| p1_rx_irq | output | 1 | Processor 1 receive interrupt |
| p1_tx_irq | output | 1 | Processor 1 transmit interrupt |

## Verification
The properties assume that reset is held high from time zero until at least one clock edge has passed. They also assume that the select, write-enable, address and data inputs are known on every edge outside reset.

The flag properties for one port only apply when the other port is not writing a conflicting command in the same cycle. For that reason, the set-wins collision is checked by the bench, not by a property.

The stimulus drives every input on the falling edge from defined values and releases select between accesses. Simultaneous writes occur only in the one deliberate collision step.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int TXB = 16;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_MASK = 4'h4;
  localparam logic [3:0] OFS_CMD  = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;
  localparam logic [AW-1:0] ADDR_CFG = 10'h3F0;
  localparam logic [AW-1:0] ADDR_VER = 10'h3F4;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank import mbox_pkg::*; #(
  parameter int CH = 16,
  parameter int ID = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          rxe,
  output logic          txe,
  output logic [CH-1:0] mrx,
  output logic [CH-1:0] mtx,
  output logic [CH-1:0] set_o,
  output logic [CH-1:0] clr_o
);
  logic own_wr;
  assign own_wr = sel && we && (addr[AW-1:4] == (AW-4)'(ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      rxe <= 1'b0;
      txe <= 1'b0;
      mrx <= '1;
      mtx <= '1;
    end else if (own_wr) begin
      if (addr[3:0] == OFS_CTRL) begin
        rxe <= wdata[0];
        txe <= wdata[TXB];
      end
      if (addr[3:0] == OFS_MASK) begin
        mrx <= wdata[CH-1:0];
        mtx <= wdata[TXB +: CH];
      end
    end
  end

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (own_wr && addr[3:0] == OFS_CMD) begin
      set_o = wdata[TXB +: CH];
      clr_o = wdata[CH-1:0];
    end
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags #(
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] set0,
  input  logic [CH-1:0] clr0,
  input  logic [CH-1:0] set1,
  input  logic [CH-1:0] clr1,
  output logic [CH-1:0] flg0,
  output logic [CH-1:0] flg1
);
  // a processor's flags are set by itself and cleared by its peer; set wins
  always_ff @(posedge clk) begin
    if (rst) begin
      flg0 <= '0;
      flg1 <= '0;
    end else begin
      flg0 <= (flg0 & ~clr1) | set0;
      flg1 <= (flg1 & ~clr0) | set1;
    end
  end
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rxe,
  input  logic          txe,
  input  logic [CH-1:0] mrx,
  input  logic [CH-1:0] mtx,
  input  logic [CH-1:0] own,
  input  logic [CH-1:0] peer,
  output logic          rx_irq,
  output logic          tx_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= rxe && |(peer & ~mrx);
      tx_irq <= txe && |(~own & ~mtx);
    end
  end
endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl import mbox_pkg::*; #(
  parameter int CH   = 16,
  parameter int VMAJ = 1,
  parameter int VMIN = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          p0_sel,
  input  logic          p0_we,
  input  logic [AW-1:0] p0_addr,
  input  logic [DW-1:0] p0_wdata,
  output logic [DW-1:0] p0_rdata,
  input  logic          p1_sel,
  input  logic          p1_we,
  input  logic [AW-1:0] p1_addr,
  input  logic [DW-1:0] p1_wdata,
  output logic [DW-1:0] p1_rdata,
  output logic          p0_rx_irq,
  output logic          p0_tx_irq,
  output logic          p1_rx_irq,
  output logic          p1_tx_irq
);
  localparam int NP = 2;

  logic [NP-1:0]          sel_a, we_a, rxe, txe, rxi, txi;
  logic [NP-1:0][AW-1:0]  addr_a;
  logic [NP-1:0][DW-1:0]  wd_a, rd_a;
  logic [NP-1:0][CH-1:0]  mrx, mtx, set_a, clr_a, flg_a;
  logic [CH-1:0]          flg0, flg1;

  assign sel_a  = {p1_sel, p0_sel};
  assign we_a   = {p1_we, p0_we};
  assign addr_a = {p1_addr, p0_addr};
  assign wd_a   = {p1_wdata, p0_wdata};
  assign flg_a  = {flg1, flg0};

  mbox_flags #(.CH(CH)) flags_i (
    .clk(clk), .rst(rst),
    .set0(set_a[0]), .clr0(clr_a[0]),
    .set1(set_a[1]), .clr1(clr_a[1]),
    .flg0(flg0), .flg1(flg1)
  );

  for (genvar g = 0; g < NP; g++) begin : g_proc
    logic [DW-1:0] rv;
    logic          bk;

    mbox_bank #(.CH(CH), .ID(g)) bank_i (
      .clk(clk), .rst(rst), .sel(sel_a[g]), .we(we_a[g]),
      .addr(addr_a[g]), .wdata(wd_a[g]),
      .rxe(rxe[g]), .txe(txe[g]), .mrx(mrx[g]), .mtx(mtx[g]),
      .set_o(set_a[g]), .clr_o(clr_a[g])
    );

    mbox_irq #(.CH(CH)) irq_i (
      .clk(clk), .rst(rst), .rxe(rxe[g]), .txe(txe[g]),
      .mrx(mrx[g]), .mtx(mtx[g]),
      .own(flg_a[g]), .peer(flg_a[NP-1-g]),
      .rx_irq(rxi[g]), .tx_irq(txi[g])
    );

    always_comb begin
      rv = '0;
      bk = addr_a[g][4];
      if (addr_a[g] == ADDR_CFG) begin
        rv[7:0] = 8'(CH);
      end else if (addr_a[g] == ADDR_VER) begin
        rv[7:0] = {4'(VMAJ), 4'(VMIN)};
      end else if (addr_a[g][AW-1:5] == '0) begin
        case (addr_a[g][3:0])
          OFS_CTRL: begin
            rv[0]   = rxe[bk];
            rv[TXB] = txe[bk];
          end
          OFS_MASK: begin
            rv[CH-1:0]    = mrx[bk];
            rv[TXB +: CH] = mtx[bk];
          end
          OFS_STAT: rv[CH-1:0] = flg_a[bk];
          default:  rv = '0;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                         rd_a[g] <= '0;
      else if (sel_a[g] && !we_a[g])   rd_a[g] <= rv;
      else                             rd_a[g] <= '0;
    end
  end

  assign p0_rdata  = rd_a[0];
  assign p1_rdata  = rd_a[1];
  assign p0_rx_irq = rxi[0];
  assign p0_tx_irq = txi[0];
  assign p1_rx_irq = rxi[1];
  assign p1_tx_irq = txi[1];
endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk #(
  parameter int CH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          p0_sel,
  input logic          p0_we,
  input logic [9:0]    p0_addr,
  input logic [31:0]   p0_wdata,
  input logic [31:0]   p0_rdata,
  input logic          p1_sel,
  input logic          p1_we,
  input logic [9:0]    p1_addr,
  input logic [31:0]   p1_wdata,
  input logic          p0_rx_irq,
  input logic          p1_tx_irq,
  input logic [1:0]    rxe,
  input logic [1:0]    txe,
  input logic [CH-1:0] flg0,
  input logic [CH-1:0] flg1
);
  logic p0_cmd, p1_cmd;
  assign p0_cmd = p0_sel && p0_we && p0_addr == 10'h008;
  assign p1_cmd = p1_sel && p1_we && p1_addr == 10'h018;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!p0_rx_irq && !p1_tx_irq));

  // R4
  own_set_chk: assert property (@(posedge clk) disable iff (rst)
    (p0_cmd && p0_wdata[16]) |=> flg0[0]);

  // R5
  peer_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (p0_cmd && p0_wdata[0] && !(p1_cmd && p1_wdata[16])) |=> !flg1[0]);

  // R6
  zero_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (p0_cmd && p0_wdata == '0 && !p1_sel) |=> ($stable(flg0) && $stable(flg1)));

  // R7
  rx_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(p0_rx_irq) |-> $past(rxe[0]));

  // R8
  tx_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    !txe[1] |=> !p1_tx_irq);

  // R11
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !(p0_sel && !p0_we) |=> p0_rdata == '0);
endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.CH(CH)) chk_i (
  .clk(clk), .rst(rst),
  .p0_sel(p0_sel), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
  .p0_rdata(p0_rdata),
  .p1_sel(p1_sel), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
  .p0_rx_irq(p0_rx_irq), .p1_tx_irq(p1_tx_irq),
  .rxe(rxe), .txe(txe), .flg0(flg0), .flg1(flg1)
);

// File: tb/mbox_flag_ctrl_tb_top.sv
module mbox_flag_ctrl_tb_top;
  localparam int CH = 6;
  localparam int VMAJ = 1;
  localparam int VMIN = 0;
  localparam logic [15:0] CHM = 16'h003F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic        s_sel [2];
  logic        s_we  [2];
  logic [9:0]  s_addr[2];
  logic [31:0] s_wd  [2];
  logic [31:0] p0_rdata, p1_rdata;
  logic p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mbox_flag_ctrl #(.CH(CH), .VMAJ(VMAJ), .VMIN(VMIN)) dut_i (
    .clk(clk), .rst(rst),
    .p0_sel(s_sel[0]), .p0_we(s_we[0]), .p0_addr(s_addr[0]), .p0_wdata(s_wd[0]),
    .p0_rdata(p0_rdata),
    .p1_sel(s_sel[1]), .p1_we(s_we[1]), .p1_addr(s_addr[1]), .p1_wdata(s_wd[1]),
    .p1_rdata(p1_rdata),
    .p0_rx_irq(p0_rx_irq), .p0_tx_irq(p0_tx_irq),
    .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq)
  );

  // behavioural reference model
  bit [15:0] m_flg[2], m_mrx[2], m_mtx[2];
  bit        m_rxe[2], m_txe[2];
  bit        e_rx[2], e_tx[2];
  bit [31:0] e_rd[2];

  function automatic bit [31:0] mread(int a);
    int k;
    if (a == 'h3F0) return CH;
    if (a == 'h3F4) return VMAJ * 16 + VMIN;
    if ((a >> 5) != 0) return 0;
    k = (a >> 4) & 1;
    case (a & 15)
      0:  return (m_txe[k] ? 32'h0001_0000 : 0) | (m_rxe[k] ? 32'h1 : 0);
      4:  return {m_mtx[k], m_mrx[k]};
      12: return {16'h0, m_flg[k]};
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [15:0] st[2], cl[2];
    if (rst) begin
      for (int p = 0; p < 2; p++) begin
        m_flg[p] = 0; m_mrx[p] = CHM; m_mtx[p] = CHM;
        m_rxe[p] = 0; m_txe[p] = 0; e_rx[p] = 0; e_tx[p] = 0; e_rd[p] = 0;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        e_rx[p] = m_rxe[p] && ((m_flg[1-p] & ~m_mrx[p] & CHM) != 0);
        e_tx[p] = m_txe[p] && ((~m_flg[p] & ~m_mtx[p] & CHM) != 0);
        e_rd[p] = (s_sel[p] && !s_we[p]) ? mread(int'(s_addr[p])) : 0;
        st[p] = 0; cl[p] = 0;
      end
      for (int p = 0; p < 2; p++) begin
        if (s_sel[p] && s_we[p] && int'(s_addr[p] >> 4) == p) begin
          case (int'(s_addr[p] & 10'hF))
            0: begin m_rxe[p] = s_wd[p][0]; m_txe[p] = s_wd[p][16]; end
            4: begin m_mrx[p] = s_wd[p][15:0] & CHM; m_mtx[p] = s_wd[p][31:16] & CHM; end
            8: begin st[p] = s_wd[p][31:16] & CHM; cl[p] = s_wd[p][15:0] & CHM; end
            default: ;
          endcase
        end
      end
      for (int p = 0; p < 2; p++) m_flg[p] = (m_flg[p] & ~cl[1-p]) | st[p];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R7 p0 rx irq", 32'(p0_rx_irq), 32'(e_rx[0]));
      chk("R7 p1 rx irq", 32'(p1_rx_irq), 32'(e_rx[1]));
      chk("R8 p0 tx irq", 32'(p0_tx_irq), 32'(e_tx[0]));
      chk("R8 p1 tx irq", 32'(p1_tx_irq), 32'(e_tx[1]));
      chk("R11 p0 rdata", p0_rdata, e_rd[0]);
      chk("R11 p1 rdata", p1_rdata, e_rd[1]);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int p, logic [9:0] a, logic [31:0] d);
    s_sel[p] = 1; s_we[p] = 1; s_addr[p] = a; s_wd[p] = d;
    @(negedge clk);
    s_sel[p] = 0; s_we[p] = 0;
  endtask

  task automatic rd(int p, logic [9:0] a, logic [31:0] exp, string tag);
    s_sel[p] = 1; s_we[p] = 0; s_addr[p] = a;
    @(negedge clk);
    chk(tag, (p == 0) ? p0_rdata : p1_rdata, exp);
    s_sel[p] = 0;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      s_sel[p] = 0; s_we[p] = 0; s_addr[p] = '0; s_wd[p] = '0;
    end
    idle(3);
    rst = 0;
    idle(1);
    // R1 reset contents
    rd(0, 10'h004, 32'h003F_003F, "R1 mask reset");
    rd(0, 10'h000, 32'h0, "R1 ctrl reset");
    rd(1, 10'h01C, 32'h0, "R1 flags reset");
    chk("R1 irqs low", {28'h0, p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq}, 32'h0);
    // R9 fixed registers
    rd(0, 10'h3F0, 32'd6, "R9 channel count");
    rd(1, 10'h3F4, 32'h10, "R9 version");
    // R3 / R10 mask bits above channel count dropped
    wr(0, 10'h004, 32'hFFFF_FFFF);
    rd(0, 10'h004, 32'h003F_003F, "R10 mask high bits");
    wr(0, 10'h004, 32'h0000_0000);
    rd(1, 10'h004, 32'h0, "R3 mask cleared");
    // R2 enable bits, cross-bank write ignored
    wr(0, 10'h000, 32'h0001_0001);
    rd(0, 10'h000, 32'h0001_0001, "R2 ctrl readback");
    rd(1, 10'h010, 32'h0, "R2 peer bank untouched");
    wr(0, 10'h010, 32'h0001_0001);
    rd(0, 10'h010, 32'h0, "R2 cross-bank write ignored");
    chk("R8 tx free unmasked", 32'(p0_tx_irq), 32'h1);
    // R4 set own flag
    wr(1, 10'h018, 32'h0004_0000);
    rd(1, 10'h01C, 32'h4, "R4 own status");
    rd(0, 10'h01C, 32'h4, "R4 status from peer");
    chk("R7 rx occupied", 32'(p0_rx_irq), 32'h1);
    // R10 command bit above count ignored
    wr(1, 10'h018, 32'h8000_0000);
    rd(1, 10'h01C, 32'h4, "R10 high cmd bit");
    // R6 zero command, command reads zero
    wr(1, 10'h018, 32'h0);
    rd(1, 10'h01C, 32'h4, "R6 zero write");
    rd(1, 10'h018, 32'h0, "R6 cmd reads zero");
    // R5 acknowledge clears peer flag
    wr(0, 10'h008, 32'h0000_0004);
    rd(1, 10'h01C, 32'h0, "R5 ack clears");
    chk("R7 rx dropped", 32'(p0_rx_irq), 32'h0);
    // R5 collision: set and clear same cycle, set wins
    s_sel[0] = 1; s_we[0] = 1; s_addr[0] = 10'h008; s_wd[0] = 32'h2;
    s_sel[1] = 1; s_we[1] = 1; s_addr[1] = 10'h018; s_wd[1] = 32'h0002_0000;
    @(negedge clk);
    s_sel[0] = 0; s_sel[1] = 0; s_we[0] = 0; s_we[1] = 0;
    rd(1, 10'h01C, 32'h2, "R5 set wins");
    // R11 unmapped read
    rd(0, 10'h100, 32'h0, "R11 unmapped");
    chk("R11 idle rdata", p0_rdata, 32'h0);
    // R8 masking and all-occupied
    wr(0, 10'h004, 32'h003F_0000);
    idle(1);
    chk("R8 tx masked", 32'(p0_tx_irq), 32'h0);
    wr(0, 10'h004, 32'h0);
    wr(0, 10'h008, 32'h003F_0000);
    idle(1);
    chk("R8 all occupied", 32'(p0_tx_irq), 32'h0);
    // R7 processor 1 receive side
    wr(1, 10'h014, 32'h0);
    wr(1, 10'h010, 32'h1);
    idle(1);
    chk("R7 p1 rx", 32'(p1_rx_irq), 32'h1);
    wr(1, 10'h018, 32'h0000_003F);
    idle(1);
    chk("R7 p1 rx cleared", 32'(p1_rx_irq), 32'h0);
    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule